// File: doc/BRIEF.md
# Macroblock Motion Compensation Sequencer

This controller steps through the motion compensation of one macroblock at a time over a single merged frame buffer. In that buffer, reconstructed pixels overwrite reference pixels in place, and a dirty table records which reference pixels have moved to a backup strip. The sequencer takes a descriptor through a valid/ready handshake. The descriptor carries a mode code, a residual-present flag and four luma motion vectors. The sequencer then drives strobes for the phases that mode needs, in order: mode check, chroma vector derivation, predicted-pixel read, reference backup, write-back and dirty-table update. A per-pixel index goes with every memory strobe.

Memory phases move one pixel per cycle, 384 pixels per macroblock (256 luma plus 128 chroma). Reconstruction is not a phase of its own. It is signalled during the reference backup, so predicted-plus-residual arithmetic runs in the shadow of the backup traffic. A macroblock whose content is unchanged from the reference does no memory traffic at all. It costs one cycle, which marks it in the dirty table.

Top module: `mc_sequencer`

## Requirements
- R1: After reset `in_ready` is 1 and every strobe, `cmv_valid` and `mb_done` are 0. `in_ready` is 1 exactly when the sequencer is idle. A descriptor is taken on a clock edge where `in_valid` and `in_ready` are both 1.
- R2: Mode code 4 (not coded) takes 1 busy cycle. In that cycle `dt_upd` and `mb_done` are both high, and no read, backup or write strobe is issued.
- R3: Mode code 0 (intra) takes 1+P busy cycles (385 at P=384). It issues P write strobes starting in busy cycle 2, with no read, backup or dirty-table update.
- R4: Mode code 1 (inter-intra) takes 2+2P busy cycles (770). It issues P backup strobes from busy cycle 2, then P write strobes, then one final cycle with `dt_upd` and `mb_done`.
- R5: Mode codes 2 (inter) and 3 (inter with four vectors) take 1+4+3P busy cycles (1157). Busy cycle 1 is the mode check, then 4 derivation cycles, then P reads, P backups and P writes. `dt_upd` and `mb_done` are high on the last write cycle.
- R6: `recon_add` is high in every backup cycle of mode 2 or 3 when the residual flag was 1, and at no other time.
- R7: Within each memory phase, `pix_idx` runs 0, 1, ..., P-1, one step per strobe cycle.
- R8: Vector k of a field occupies bits [k*MV_W +: MV_W], two's complement. For mode 2 the chroma vector is vector 0 divided by 2. For mode 3 it is the sum of the four vectors divided by 8. Both divisions round half away from zero. `cmv_x`/`cmv_y` carry the result from the first read cycle on. `cmv_valid` is high only in that cycle.
- R9: `mb_done` is high for exactly one cycle per macroblock: the last busy cycle. At most one of read, backup and write is active in any cycle.
- R10: Mode codes 5, 6 and 7 are handled exactly as mode code 4.
- R11: Descriptor inputs presented while busy have no effect. Latency, strobe counts and chroma result follow the descriptor that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Sequencer idle, can accept a descriptor |
| in_mode | input | 3 | Mode code (0 intra, 1 inter-intra, 2 inter, 3 inter four-vector, 4 not coded) |
| in_resid | input | 1 | Residual present |
| in_mvx | input | 4*MV_W | Four horizontal luma vectors |
| in_mvy | input | 4*MV_W | Four vertical luma vectors |
| rd_stb | output | 1 | Predicted-pixel read strobe |
| bk_stb | output | 1 | Reference backup strobe |
| wr_stb | output | 1 | Write-back strobe |
| recon_add | output | 1 | Reconstruction adder enable |
| dt_upd | output | 1 | Dirty-table update strobe |
| pix_idx | output | clog2(P) | Pixel index within the current memory phase |
| cmv_x | output | MV_W | Derived horizontal chroma vector |
| cmv_y | output | MV_W | Derived vertical chroma vector |
| cmv_valid | output | 1 | Chroma vector freshly available |
| mb_done | output | 1 | Last cycle of the macroblock |

## Verification
The bench builds the block with the full 384 pixels per macroblock, so every busy-cycle total is checked at its real value. Vectors are 6 bits wide, so each axis spans -32 to 31. With that width, the most negative four-vector sums, the largest single vectors and the exact half-way rounding points can all be reached among a small number of macroblocks. Every mode code, including the three unused ones, is swept with and without a residual. The three longer modes are also run with a conflicting descriptor held on the inputs while busy.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int NUM_VEC = 4;

  typedef enum logic [2:0] {
    MB_INTRA       = 3'd0,
    MB_INTER_INTRA = 3'd1,
    MB_INTER       = 3'd2,
    MB_INTER4V     = 3'd3,
    MB_SKIP        = 3'd4
  } mb_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHECK,
    PH_CMV,
    PH_READ,
    PH_BACKUP,
    PH_WRITE,
    PH_DIRTY
  } phase_e;

  // Unused codes fall back to the no-access mode.
  function automatic mb_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd0:    return MB_INTRA;
      3'd1:    return MB_INTER_INTRA;
      3'd2:    return MB_INTER;
      3'd3:    return MB_INTER4V;
      default: return MB_SKIP;
    endcase
  endfunction

  // Division by 2**sh, rounding half away from zero.
  function automatic logic signed [31:0] round_away(input logic signed [31:0] num,
                                                    input int sh);
    logic [31:0] mag;
    logic [31:0] q;
    mag = num[31] ? 32'(-num) : 32'(num);
    q   = (mag + (32'd1 << (sh - 1))) >> sh;
    return num[31] ? -$signed(q) : $signed(q);
  endfunction

endpackage

// File: rtl/mcs_step_counter.sv
module mcs_step_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         last
);

  assign last = (count == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (en) begin
      count <= last ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/mcs_phase_ctrl.sv
module mcs_phase_ctrl
  import mcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  mb_mode_e mode,
  input  logic     step_last,
  output phase_e   phase
);

  phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    case (phase)
      PH_IDLE:   if (accept) phase_nxt = PH_CHECK;
      PH_CHECK: begin
        case (mode)
          MB_INTRA:       phase_nxt = PH_WRITE;
          MB_INTER_INTRA: phase_nxt = PH_BACKUP;
          MB_INTER,
          MB_INTER4V:     phase_nxt = PH_CMV;
          default:        phase_nxt = PH_IDLE;
        endcase
      end
      PH_CMV:    if (step_last) phase_nxt = PH_READ;
      PH_READ:   if (step_last) phase_nxt = PH_BACKUP;
      PH_BACKUP: if (step_last) phase_nxt = PH_WRITE;
      PH_WRITE:  if (step_last) phase_nxt = (mode == MB_INTER_INTRA) ? PH_DIRTY : PH_IDLE;
      PH_DIRTY:  phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nxt;
  end

endmodule

// File: rtl/mcs_chroma_axis.sv
module mcs_chroma_axis
  import mcs_pkg::*;
#(
  parameter int MV_W  = 8,
  parameter int IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      all4,
  input  logic [NUM_VEC*MV_W-1:0]   vecs,
  output logic [MV_W-1:0]           cmv
);

  localparam int ACC_W = MV_W + $clog2(NUM_VEC);

  logic signed [MV_W-1:0]  cur;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [31:0]      wide;
  logic signed [31:0]      rounded;

  assign cur     = vecs[idx*MV_W +: MV_W];
  assign term    = (all4 || idx == '0) ? ACC_W'(cur) : '0;
  assign acc_nxt = ((idx == '0) ? '0 : acc) + term;
  assign wide    = {{(32-ACC_W){acc_nxt[ACC_W-1]}}, acc_nxt};
  assign rounded = round_away(wide, all4 ? $clog2(2*NUM_VEC) : 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cmv <= '0;
    end else if (step) begin
      acc <= acc_nxt;
      if (idx == IDX_W'(NUM_VEC - 1)) cmv <= rounded[MV_W-1:0];
    end
  end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mcs_pkg::*;
#(
  parameter int PIX_PER_MB = 384,
  parameter int MV_W       = 8,
  localparam int PIX_W     = $clog2(PIX_PER_MB)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              in_mode,
  input  logic                    in_resid,
  input  logic [NUM_VEC*MV_W-1:0] in_mvx,
  input  logic [NUM_VEC*MV_W-1:0] in_mvy,
  output logic                    rd_stb,
  output logic                    bk_stb,
  output logic                    wr_stb,
  output logic                    recon_add,
  output logic                    dt_upd,
  output logic [PIX_W-1:0]        pix_idx,
  output logic [MV_W-1:0]         cmv_x,
  output logic [MV_W-1:0]         cmv_y,
  output logic                    cmv_valid,
  output logic                    mb_done
);

  localparam int IDX_W = $clog2(NUM_VEC);

  phase_e                  phase;
  mb_mode_e                mode_q;
  logic                    resid_q;
  logic [NUM_VEC*MV_W-1:0] mv_q [2];
  logic [MV_W-1:0]         cmv_arr [2];
  logic                    accept;
  logic                    step_en;
  logic                    step_last;
  logic [PIX_W-1:0]        step_cnt;
  logic [PIX_W-1:0]        step_lim;
  logic                    is_inter;
  logic                    is_skip;
  logic                    mem_phase;

  assign accept    = in_valid && (phase == PH_IDLE);
  assign is_inter  = (mode_q == MB_INTER) || (mode_q == MB_INTER4V);
  assign is_skip   = (mode_q == MB_SKIP);
  assign mem_phase = (phase == PH_READ) || (phase == PH_BACKUP) || (phase == PH_WRITE);
  assign step_en   = mem_phase || (phase == PH_CMV);
  assign step_lim  = (phase == PH_CMV) ? PIX_W'(NUM_VEC - 1) : PIX_W'(PIX_PER_MB - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MB_SKIP;
      resid_q <= 1'b0;
      mv_q[0] <= '0;
      mv_q[1] <= '0;
    end else if (accept) begin
      mode_q  <= decode_mode(in_mode);
      resid_q <= in_resid;
      mv_q[0] <= in_mvx;
      mv_q[1] <= in_mvy;
    end
  end

  mcs_phase_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .mode      (mode_q),
    .step_last (step_last),
    .phase     (phase)
  );

  mcs_step_counter #(.W(PIX_W)) i_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (step_en),
    .limit (step_lim),
    .count (step_cnt),
    .last  (step_last)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    mcs_chroma_axis #(.MV_W(MV_W), .IDX_W(IDX_W)) i_axis (
      .clk  (clk),
      .rst  (rst),
      .step (phase == PH_CMV),
      .idx  (step_cnt[IDX_W-1:0]),
      .all4 (mode_q == MB_INTER4V),
      .vecs (mv_q[a]),
      .cmv  (cmv_arr[a])
    );
  end

  assign cmv_x     = cmv_arr[0];
  assign cmv_y     = cmv_arr[1];
  assign in_ready  = (phase == PH_IDLE);
  assign rd_stb    = (phase == PH_READ);
  assign bk_stb    = (phase == PH_BACKUP);
  assign wr_stb    = (phase == PH_WRITE);
  assign recon_add = (phase == PH_BACKUP) && is_inter && resid_q;
  assign pix_idx   = mem_phase ? step_cnt : '0;
  assign cmv_valid = (phase == PH_READ) && (step_cnt == '0);
  assign dt_upd    = ((phase == PH_CHECK) && is_skip) || (phase == PH_DIRTY) ||
                     ((phase == PH_WRITE) && step_last && is_inter);
  assign mb_done   = ((phase == PH_CHECK) && is_skip) || (phase == PH_DIRTY) ||
                     ((phase == PH_WRITE) && step_last && (mode_q != MB_INTER_INTRA));

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic rd_stb,
  input logic bk_stb,
  input logic wr_stb,
  input logic recon_add,
  input logic cmv_valid,
  input logic mb_done
);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !(rd_stb || bk_stb || wr_stb || recon_add));

  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    mb_done |=> in_ready && !mb_done);

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({rd_stb, bk_stb, wr_stb}) <= 1);

  a_r6_recon_in_backup: assert property (@(posedge clk) disable iff (rst)
    recon_add |-> bk_stb);

  a_r8_cmv_first_read: assert property (@(posedge clk) disable iff (rst)
    cmv_valid |-> rd_stb && !$past(rd_stb));

  a_r5_read_into_backup: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_stb) |-> bk_stb);

endmodule

bind mc_sequencer mcs_checker i_mcs_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rd_stb    (rd_stb),
  .bk_stb    (bk_stb),
  .wr_stb    (wr_stb),
  .recon_add (recon_add),
  .cmv_valid (cmv_valid),
  .mb_done   (mb_done)
);

// File: tb/test_mc_sequencer.sv
module test_mc_sequencer;

  localparam int P  = 384;
  localparam int C  = 4;
  localparam int MW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_mode = '0;
  logic          in_resid = 1'b0;
  logic [4*MW-1:0] in_mvx = '0;
  logic [4*MW-1:0] in_mvy = '0;
  logic          rd_stb, bk_stb, wr_stb, recon_add, dt_upd, cmv_valid, mb_done;
  logic [8:0]    pix_idx;
  logic [MW-1:0] cmv_x, cmv_y;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  mc_sequencer #(.PIX_PER_MB(P), .MV_W(MW)) i_mc_sequencer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_resid(in_resid), .in_mvx(in_mvx), .in_mvy(in_mvy),
    .rd_stb(rd_stb), .bk_stb(bk_stb), .wr_stb(wr_stb), .recon_add(recon_add),
    .dt_upd(dt_upd), .pix_idx(pix_idx), .cmv_x(cmv_x), .cmv_y(cmv_y),
    .cmv_valid(cmv_valid), .mb_done(mb_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_chroma(input int m, input logic [4*MW-1:0] v);
    int s, d, a, q;
    s = 0;
    if (m == 2) begin
      s = int'($signed(v[0 +: MW]));
      d = 2;
    end else begin
      for (int k = 0; k < 4; k++) s += int'($signed(v[k*MW +: MW]));
      d = 8;
    end
    a = (s < 0) ? -s : s;
    q = (a + d / 2) / d;
    return (s < 0) ? -q : q;
  endfunction

  task automatic run_mb(input logic [2:0] code, input bit resid,
                        input logic [4*MW-1:0] mx, input logic [4*MW-1:0] my,
                        input bit noisy);
    int m, n, lat;
    int n_rd, n_bk, n_wr, n_dt, n_rc, n_cv;
    int f_rd, f_bk, f_wr, l_dt, cv_at, busy_bad, pix_bad;
    int e_rd, e_bk, e_wr, e_dt, e_rc;
    m = (code > 3'd3) ? 4 : int'(code);
    n_rd = 0; n_bk = 0; n_wr = 0; n_dt = 0; n_rc = 0; n_cv = 0;
    f_rd = 0; f_bk = 0; f_wr = 0; l_dt = 0; cv_at = 0; busy_bad = 0; pix_bad = 0;
    @(negedge clk);
    in_valid = 1'b1; in_mode = code; in_resid = resid; in_mvx = mx; in_mvy = my;
    @(negedge clk);
    if (noisy) begin
      // R11: conflicting descriptor held while busy
      in_mode = (code == 3'd2) ? 3'd0 : 3'd2; in_resid = ~resid;
      in_mvx = ~mx; in_mvy = mx;
    end else begin
      in_valid = 1'b0;
    end
    n = 1;
    forever begin
      if (noisy && n == 10) in_valid = 1'b0;
      if (rd_stb) begin
        if (n_rd == 0) f_rd = n;
        if (int'(pix_idx) != n_rd) pix_bad++;
        n_rd++;
      end
      if (bk_stb) begin
        if (n_bk == 0) f_bk = n;
        if (int'(pix_idx) != n_bk) pix_bad++;
        n_bk++;
      end
      if (wr_stb) begin
        if (n_wr == 0) f_wr = n;
        if (int'(pix_idx) != n_wr) pix_bad++;
        n_wr++;
      end
      if (dt_upd) begin n_dt++; l_dt = n; end
      if (recon_add) n_rc++;
      if (cmv_valid) begin n_cv++; cv_at = n; end
      if (mb_done) break;
      if (in_ready) busy_bad++;
      if (n > 5000) break;
      n++;
      @(negedge clk);
    end
    lat = n;
    case (m)
      0: begin e_rd = 0; e_bk = 0; e_wr = P; e_dt = 0; end
      1: begin e_rd = 0; e_bk = P; e_wr = P; e_dt = 1; end
      2, 3: begin e_rd = P; e_bk = P; e_wr = P; e_dt = 1; end
      default: begin e_rd = 0; e_bk = 0; e_wr = 0; e_dt = 1; end
    endcase
    e_rc = ((m == 2 || m == 3) && resid) ? P : 0;
    case (m)
      0: chk(lat == 1 + P, "R3", "intra latency", lat, 1 + P);
      1: chk(lat == 2 + 2*P, "R4", "inter-intra latency", lat, 2 + 2*P);
      2, 3: chk(lat == 1 + C + 3*P, "R5", "inter latency", lat, 1 + C + 3*P);
      default: chk(lat == 1, (code == 3'd4) ? "R2" : "R10", "not-coded latency", lat, 1);
    endcase
    chk(busy_bad == 0, "R1", "ready while busy", busy_bad, 0);
    chk(n_rd == e_rd, "R5", "read strobes", n_rd, e_rd);
    chk(n_bk == e_bk, "R4", "backup strobes", n_bk, e_bk);
    chk(n_wr == e_wr, "R3", "write strobes", n_wr, e_wr);
    chk(n_dt == e_dt, "R2", "dirty updates", n_dt, e_dt);
    if (e_dt == 1) chk(l_dt == lat, "R9", "dirty update cycle", l_dt, lat);
    chk(n_rc == e_rc, "R6", "recon cycles", n_rc, e_rc);
    chk(pix_bad == 0, "R7", "pixel index errors", pix_bad, 0);
    if (m == 0) chk(f_wr == 2, "R3", "first write cycle", f_wr, 2);
    if (m == 1) begin
      chk(f_bk == 2, "R4", "first backup cycle", f_bk, 2);
      chk(f_wr == 2 + P, "R4", "first write cycle", f_wr, 2 + P);
    end
    if (m == 2 || m == 3) begin
      chk(f_rd == 2 + C, "R5", "first read cycle", f_rd, 2 + C);
      chk(f_bk == 2 + C + P, "R5", "first backup cycle", f_bk, 2 + C + P);
      chk(f_wr == 2 + C + 2*P, "R5", "first write cycle", f_wr, 2 + C + 2*P);
      chk(n_cv == 1 && cv_at == f_rd, "R8", "cmv_valid cycle", cv_at, f_rd);
      chk(int'($signed(cmv_x)) == exp_chroma(m, mx), "R8", "chroma x",
          int'($signed(cmv_x)), exp_chroma(m, mx));
      chk(int'($signed(cmv_y)) == exp_chroma(m, my), "R8", "chroma y",
          int'($signed(cmv_y)), exp_chroma(m, my));
    end else begin
      chk(n_cv == 0, "R8", "cmv_valid count", n_cv, 0);
    end
    @(negedge clk);
    chk(in_ready && !mb_done, "R9", "idle after done", int'({in_ready, mb_done}), 2);
  endtask

  function automatic logic [4*MW-1:0] pack4(input int a, input int b, input int c, input int d);
    return {MW'(d), MW'(c), MW'(b), MW'(a)};
  endfunction

  function automatic logic [4*MW-1:0] rnd_vec();
    logic [4*MW-1:0] v;
    for (int k = 0; k < 4; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      v[k*MW +: MW] = seed[21:16];
    end
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk({rd_stb, bk_stb, wr_stb, recon_add, dt_upd, cmv_valid, mb_done} == '0,
        "R1", "quiet after reset",
        int'({rd_stb, bk_stb, wr_stb, recon_add, dt_upd, cmv_valid, mb_done}), 0);

    // All mode codes (R2..R6, R10), with and without residual
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 2; r++) begin
        run_mb(3'(c), r[0], pack4(5, -7, 12, -1), pack4(-3, 9, -16, 4), 1'b0);
      end
    end

    // R11: busy-time inputs ignored
    run_mb(3'd1, 1'b1, pack4(1, 2, 3, 4), pack4(4, 3, 2, 1), 1'b1);
    run_mb(3'd2, 1'b0, pack4(7, 0, 0, 0), pack4(-7, 0, 0, 0), 1'b1);
    run_mb(3'd3, 1'b1, pack4(-32, -32, -32, -32), pack4(31, 31, 31, 31), 1'b1);

    // R8 rounding corners: half points and extremes
    run_mb(3'd3, 1'b0, pack4(1, 1, 1, 1), pack4(-1, -1, -1, -1), 1'b0);
    run_mb(3'd3, 1'b0, pack4(1, 1, 1, 0), pack4(-1, -1, -1, 0), 1'b0);
    run_mb(3'd3, 1'b0, pack4(3, 3, 3, 3), pack4(-3, -3, -3, -3), 1'b0);
    run_mb(3'd2, 1'b0, pack4(1, 9, 9, 9), pack4(-1, 9, 9, 9), 1'b0);
    run_mb(3'd2, 1'b0, pack4(31, 0, 0, 0), pack4(-32, 0, 0, 0), 1'b0);
    run_mb(3'd2, 1'b0, pack4(-3, 0, 0, 0), pack4(3, 0, 0, 0), 1'b0);

    // R8 pseudo-random sweep
    for (int i = 0; i < 36; i++) run_mb(3'd3, 1'b1, rnd_vec(), rnd_vec(), 1'b0);
    for (int i = 0; i < 14; i++) run_mb(3'd2, 1'b1, rnd_vec(), rnd_vec(), 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule